// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block loads a configuration image into a target FPGA through the target's bit-serial slave port. On a start command it pulls the target's active-low program line low for a fixed number of cycles and then releases it. Next it waits, up to a time limit, for the target to raise its init-ready line. It then takes the requested number of bytes from a byte source and shifts each one out most significant bit first. Every bit gets exactly one configuration-clock pulse, and the data line is settled before the clock rises.

After the last byte the block keeps pulsing the configuration clock until the target raises done. If done does not rise within a pulse limit, the block stops with a done-timeout result. A missing init-ready gives an init-timeout result. An error flagged by the byte source aborts the load at once. The result flag holds until the next start, and a busy flag covers the whole load.

The controller is one state machine with these states: IDLE, PROG_LOW, WAIT_INIT, FETCH, BIT_LOW, BIT_HIGH, TRAIL_LOW, TRAIL_HIGH, and the terminal states OK, ERR_INIT, ERR_DONE, ERR_SRC. Its transitions are:
- IDLE or any terminal state goes to PROG_LOW on start.
- PROG_LOW goes to WAIT_INIT when the pulse width has elapsed.
- WAIT_INIT goes to FETCH when init-ready is seen high, or to TRAIL_LOW instead if the length is zero. It goes to ERR_INIT on timeout.
- FETCH goes to BIT_LOW when a byte is accepted, or to ERR_SRC on a source error.
- BIT_LOW goes to BIT_HIGH after one half period.
- BIT_HIGH goes to BIT_LOW while bits remain in the byte. After the last bit it goes to FETCH if bytes remain, or to TRAIL_LOW if none do.
- TRAIL_LOW goes to OK if done is high. Otherwise it goes to ERR_DONE if the pulse budget is spent, or to TRAIL_HIGH if it is not.
- TRAIL_HIGH goes back to TRAIL_LOW.

The init-ready and done inputs pass through synchronizers of SYNC_STAGES flops before the state machine uses them. This requires HALF_DIV >= 2 and PROG_LOW_CYC > SYNC_STAGES.

Top module: `cfg_loader`

## Requirements
- R1: After reset prog_n_o is 1 and cfg_clk_o, busy_o, byte_ready_o, ok_o, err_init_o, err_done_o and err_src_o are all 0.
- R2: A start pulse seen in IDLE or a terminal state drives prog_n_o low from the next cycle for exactly PROG_LOW_CYC cycles. busy_o is 1 from that next cycle until a terminal state is reached.
- R3: No cfg_clk_o pulse occurs before init-ready is seen high. If it stays low for INIT_TIMEOUT+1 cycles after prog_n_o rises, the load ends with err_init_o=1 and zero clock pulses.
- R4: Each configuration-clock pulse is high for exactly HALF_DIV cycles. cfg_din_o is stable across every rising edge of cfg_clk_o. Bits of a byte leave most significant first (bit 7 on the first pulse).
- R5: A byte is taken only in a cycle with byte_ready_o=1 and byte_valid_i=1. A load of len_i bytes produces exactly 8*len_i data pulses carrying those bytes in order, and len_i=0 produces none. A source that withholds byte_valid_i stalls the load without losing or repeating data.
- R6: byte_err_i=1 while byte_ready_o=1 ends the load with err_src_o=1, after exactly 8*k data pulses for an error at byte index k.
- R7: After the data, done is checked at the end of each low phase. The load ends with ok_o=1 as soon as done is high, having issued only the extra pulses needed, up to and including DONE_TIMEOUT extra pulses.
- R8: If done is still low after DONE_TIMEOUT extra pulses, the load ends with err_done_o=1 and exactly 8*len_i+DONE_TIMEOUT pulses in total.
- R9: start_i is ignored while busy_o=1. A start from a terminal state clears the result flag and begins a new load.
- R10: At most one result flag is 1 at any time and none while busy_o=1. A result flag holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start command |
| len_i | input | LEN_W | Image length in bytes, captured at start |
| byte_data_i | input | 8 | Byte from the image source |
| byte_valid_i | input | 1 | byte_data_i holds a valid byte |
| byte_err_i | input | 1 | Image source reports a failure |
| byte_ready_o | output | 1 | Controller is waiting for a byte |
| init_ready_i | input | 1 | Target ready for data (idle high) |
| done_i | input | 1 | Target configuration complete (idle high) |
| prog_n_o | output | 1 | Active-low program line to the target |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_din_o | output | 1 | Serial configuration data to the target |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Load finished, done seen |
| err_init_o | output | 1 | Init-ready timeout |
| err_done_o | output | 1 | Done timeout |
| err_src_o | output | 1 | Load aborted by byte source error |

## Verification
A wrong state or a stuck counter in this block becomes visible at the target pins within one configuration-clock period. It shows up as a program pulse of the wrong width, a clock pulse that starts before init-ready, a high phase of the wrong length, or a data bit that changes next to a rising edge. Counting errors in the bit or byte counter change the pulse total and the reconstructed bytes by the end of the load. Faults in the timeout logic move the terminal flag or change the pulse count it ends with. The bench models the target: it rebuilds bytes from the pins and controls init-ready and done, so each such fault shows up in the first load that reaches the affected state.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_LOW,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_TRAIL_LOW,
        ST_TRAIL_HIGH,
        ST_OK,
        ST_ERR_INIT,
        ST_ERR_DONE,
        ST_ERR_SRC
    } load_state_t;

    // Bits needed to hold values 0..maxv
    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
    parameter int unsigned WIDTH     = 2,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL}};
                end else if (STAGES == 1) begin
                    chain_q[0] <= async_i[g];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                end
            end
            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfg_down_counter.sv
module cfg_down_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    input  logic         dec_i,
    output logic [W-1:0] count_o,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int unsigned IDX_W = (DATA_W < 2) ? 1 : $clog2(DATA_W);

    logic [DATA_W-1:0] sr_q;
    logic [IDX_W-1:0]  left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sr_q   <= byte_i;
            left_q <= IDX_W'(DATA_W - 1);
        end else if (shift_i) begin
            sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
            left_q <= left_q - IDX_W'(1);
        end
    end

    assign bit_o  = sr_q[DATA_W-1];
    assign last_o = (left_q == '0);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned LEN_W        = 16,
    parameter int unsigned HALF_DIV     = 4,
    parameter int unsigned PROG_LOW_CYC = 64,
    parameter int unsigned INIT_TIMEOUT = 100000,
    parameter int unsigned DONE_TIMEOUT = 1000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    input  logic             byte_err_i,
    output logic             byte_ready_o,
    input  logic             init_ready_i,
    input  logic             done_i,
    output logic             prog_n_o,
    output logic             cfg_clk_o,
    output logic             cfg_din_o,
    output logic             busy_o,
    output logic             ok_o,
    output logic             err_init_o,
    output logic             err_done_o,
    output logic             err_src_o
);
    localparam int unsigned PH_W   = cnt_width(HALF_DIV - 1);
    localparam int unsigned WT_A   = (PROG_LOW_CYC > INIT_TIMEOUT) ? PROG_LOW_CYC : INIT_TIMEOUT;
    localparam int unsigned WT_MAX = (WT_A > DONE_TIMEOUT) ? WT_A : DONE_TIMEOUT;
    localparam int unsigned WT_W   = cnt_width(WT_MAX);

    load_state_t state_q, state_d;

    // synchronized target status
    logic [1:0] tgt_sync;
    logic       init_s, done_s;

    cfg_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_ready_i}),
        .sync_o  (tgt_sync)
    );
    assign init_s = tgt_sync[0];
    assign done_s = tgt_sync[1];

    // phase counter: cycles per clock half period
    logic            ph_load, ph_zero;
    logic [PH_W-1:0] ph_cnt;
    cfg_down_counter #(.W(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ph_load),
        .value_i (PH_W'(HALF_DIV - 1)),
        .dec_i   (1'b1),
        .count_o (ph_cnt),
        .zero_o  (ph_zero)
    );

    // wait counter: program width, init timeout, trailing pulse budget
    logic            wt_load, wt_dec, wt_zero;
    logic [WT_W-1:0] wt_val, wt_cnt;
    cfg_down_counter #(.W(WT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (wt_load),
        .value_i (wt_val),
        .dec_i   (wt_dec),
        .count_o (wt_cnt),
        .zero_o  (wt_zero)
    );

    // byte counter: bytes still to fetch
    logic             by_load, by_dec, by_zero;
    logic [LEN_W-1:0] by_cnt;
    cfg_down_counter #(.W(LEN_W)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (by_load),
        .value_i (len_i),
        .dec_i   (by_dec),
        .count_o (by_cnt),
        .zero_o  (by_zero)
    );

    // serializer
    logic sh_load, sh_shift, sh_bit, sh_last;
    cfg_bit_shifter #(.DATA_W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .byte_i  (byte_data_i),
        .shift_i (sh_shift),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath control
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        wt_load  = 1'b0;
        wt_val   = '0;
        wt_dec   = 1'b0;
        by_load  = 1'b0;
        by_dec   = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_OK, ST_ERR_INIT, ST_ERR_DONE, ST_ERR_SRC: begin
                if (start_i) begin
                    state_d = ST_PROG_LOW;
                    wt_load = 1'b1;
                    wt_val  = WT_W'(PROG_LOW_CYC - 1);
                    by_load = 1'b1;
                end
            end
            ST_PROG_LOW: begin
                if (wt_zero) begin
                    state_d = ST_WAIT_INIT;
                    wt_load = 1'b1;
                    wt_val  = WT_W'(INIT_TIMEOUT);
                end else begin
                    wt_dec = 1'b1;
                end
            end
            ST_WAIT_INIT: begin
                if (init_s) begin
                    if (by_zero) begin
                        state_d = ST_TRAIL_LOW;
                        ph_load = 1'b1;
                        wt_load = 1'b1;
                        wt_val  = WT_W'(DONE_TIMEOUT);
                    end else begin
                        state_d = ST_FETCH;
                    end
                end else if (wt_zero) begin
                    state_d = ST_ERR_INIT;
                end else begin
                    wt_dec = 1'b1;
                end
            end
            ST_FETCH: begin
                if (byte_err_i) begin
                    state_d = ST_ERR_SRC;
                end else if (byte_valid_i) begin
                    state_d = ST_BIT_LOW;
                    sh_load = 1'b1;
                    by_dec  = 1'b1;
                    ph_load = 1'b1;
                end
            end
            ST_BIT_LOW: begin
                if (ph_zero) begin
                    state_d = ST_BIT_HIGH;
                    ph_load = 1'b1;
                end
            end
            ST_BIT_HIGH: begin
                if (ph_zero) begin
                    if (!sh_last) begin
                        state_d  = ST_BIT_LOW;
                        sh_shift = 1'b1;
                        ph_load  = 1'b1;
                    end else if (by_zero) begin
                        state_d = ST_TRAIL_LOW;
                        ph_load = 1'b1;
                        wt_load = 1'b1;
                        wt_val  = WT_W'(DONE_TIMEOUT);
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_TRAIL_LOW: begin
                if (ph_zero) begin
                    if (done_s) begin
                        state_d = ST_OK;
                    end else if (wt_zero) begin
                        state_d = ST_ERR_DONE;
                    end else begin
                        state_d = ST_TRAIL_HIGH;
                        ph_load = 1'b1;
                        wt_dec  = 1'b1;
                    end
                end
            end
            ST_TRAIL_HIGH: begin
                if (ph_zero) begin
                    state_d = ST_TRAIL_LOW;
                    ph_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs, decoded from the registered state
    always_comb begin
        prog_n_o     = (state_q != ST_PROG_LOW);
        cfg_clk_o    = (state_q == ST_BIT_HIGH) || (state_q == ST_TRAIL_HIGH);
        cfg_din_o    = ((state_q == ST_BIT_LOW) || (state_q == ST_BIT_HIGH)) ? sh_bit : 1'b0;
        byte_ready_o = (state_q == ST_FETCH);
        ok_o         = (state_q == ST_OK);
        err_init_o   = (state_q == ST_ERR_INIT);
        err_done_o   = (state_q == ST_ERR_DONE);
        err_src_o    = (state_q == ST_ERR_SRC);
        busy_o       = !((state_q == ST_IDLE) || (state_q == ST_OK) || (state_q == ST_ERR_INIT)
                         || (state_q == ST_ERR_DONE) || (state_q == ST_ERR_SRC));
    end

    // counter values kept for visibility of the datapath width
    logic unused_cnts;
    assign unused_cnts = ^{ph_cnt, wt_cnt, by_cnt};

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic prog_n_o,
    input logic cfg_clk_o,
    input logic cfg_din_o,
    input logic byte_ready_o,
    input logic busy_o,
    input logic ok_o,
    input logic err_init_o,
    input logic err_done_o,
    input logic err_src_o
);
    p_single_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, err_init_o, err_done_o, err_src_o}));

    p_busy_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(ok_o || err_init_o || err_done_o || err_src_o));

    p_ok_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && !start_i) |=> ok_o);

    p_prog_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n_o) |-> $past(start_i));

    p_prog_quiet_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (busy_o && !cfg_clk_o));

    p_din_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk_o) |-> $stable(cfg_din_o));

    p_ready_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (busy_o && !cfg_clk_o));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && prog_n_o && start_i) |=> prog_n_o);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .prog_n_o     (prog_n_o),
    .cfg_clk_o    (cfg_clk_o),
    .cfg_din_o    (cfg_din_o),
    .byte_ready_o (byte_ready_o),
    .busy_o       (busy_o),
    .ok_o         (ok_o),
    .err_init_o   (err_init_o),
    .err_done_o   (err_done_o),
    .err_src_o    (err_src_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int PROG_LOW   = 4;
    localparam int INIT_TO    = 20;
    localparam int DONE_TO    = 6;
    localparam int LEN_W      = 16;

    // codes: 0 ok, 1 init timeout, 2 done timeout, 3 source error
    // fields: len, init delay (255 never), done extra (255 never), err index (255 none), stall, code
    localparam logic [47:0] VECS [0:6] = '{
        {8'd3, 8'd5,   8'd2,   8'd255, 8'd0, 8'd0},
        {8'd0, 8'd3,   8'd1,   8'd255, 8'd0, 8'd0},
        {8'd2, 8'd255, 8'd0,   8'd255, 8'd0, 8'd1},
        {8'd4, 8'd2,   8'd255, 8'd255, 8'd0, 8'd2},
        {8'd5, 8'd1,   8'd3,   8'd2,   8'd0, 8'd3},
        {8'd6, 8'd4,   8'd6,   8'd255, 8'd1, 8'd0},
        {8'd2, 8'd12,  8'd0,   8'd255, 8'd1, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] len_i;
    logic [7:0] byte_data_i;
    logic byte_valid_i, byte_err_i, byte_ready_o;
    logic init_ready_i, done_i;
    logic prog_n_o, cfg_clk_o, cfg_din_o, busy_o;
    logic ok_o, err_init_o, err_done_o, err_src_o;

    int n_chk = 0;
    int n_bad = 0;

    // current vector configuration
    int vlen = 0, videl = 0, vdext = 0, verr = 255, vstall = 0, vidx = 0;

    // target and source model state
    logic armed, init_low, clk_prev, hi_bad, tog;
    int init_cnt, pulses, bitcnt, nbytes, prog_run, prog_width, hi_run, wait_cyc, byte_idx;
    logic [7:0] shreg;
    logic [7:0] cap_mem [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] img_byte(input int v, input int i);
        return 8'((i * 29 + v * 53 + 165) & 255);
    endfunction

    function automatic int done_after();
        return (vdext == 255) ? 1000000 : 8 * vlen + vdext;
    endfunction

    assign len_i        = LEN_W'(vlen);
    assign byte_data_i  = img_byte(vidx, byte_idx);
    assign byte_valid_i = (vstall == 0) || tog;
    assign byte_err_i   = (verr != 255) && (byte_idx == verr);
    assign init_ready_i = !init_low;
    assign done_i       = !armed || (pulses >= done_after());

    cfg_loader #(
        .LEN_W(LEN_W), .HALF_DIV(HALF_DIV), .PROG_LOW_CYC(PROG_LOW),
        .INIT_TIMEOUT(INIT_TO), .DONE_TIMEOUT(DONE_TO), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_err_i(byte_err_i),
        .byte_ready_o(byte_ready_o), .init_ready_i(init_ready_i), .done_i(done_i),
        .prog_n_o(prog_n_o), .cfg_clk_o(cfg_clk_o), .cfg_din_o(cfg_din_o),
        .busy_o(busy_o), .ok_o(ok_o), .err_init_o(err_init_o),
        .err_done_o(err_done_o), .err_src_o(err_src_o)
    );

    // target model: rebuilds bytes from the pins and drives init-ready and done
    always @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0; init_low <= 1'b0; clk_prev <= 1'b0; hi_bad <= 1'b0; tog <= 1'b0;
            init_cnt <= 0; pulses <= 0; bitcnt <= 0; nbytes <= 0; prog_run <= 0;
            prog_width <= 0; hi_run <= 0; wait_cyc <= 0; byte_idx <= 0; shreg <= '0;
        end else begin
            tog      <= ~tog;
            clk_prev <= cfg_clk_o;
            if (!prog_n_o) begin
                armed <= 1'b1; init_low <= 1'b1; init_cnt <= 0; pulses <= 0;
                bitcnt <= 0; nbytes <= 0; hi_bad <= 1'b0; wait_cyc <= 0; byte_idx <= 0;
                prog_run <= prog_run + 1;
            end else begin
                if (prog_run != 0) begin
                    prog_width <= prog_run;
                    prog_run   <= 0;
                end
                if (init_low) begin
                    if (videl != 255 && init_cnt == videl) init_low <= 1'b0;
                    else init_cnt <= init_cnt + 1;
                end
                if (busy_o && pulses == 0) wait_cyc <= wait_cyc + 1;
                if (cfg_clk_o && !clk_prev) begin
                    pulses <= pulses + 1;
                    shreg  <= {shreg[6:0], cfg_din_o};
                    if (bitcnt == 7) begin
                        if (nbytes < 64) cap_mem[nbytes] <= {shreg[6:0], cfg_din_o};
                        nbytes <= nbytes + 1;
                        bitcnt <= 0;
                    end else begin
                        bitcnt <= bitcnt + 1;
                    end
                end
                if (cfg_clk_o) begin
                    hi_run <= hi_run + 1;
                end else if (hi_run != 0) begin
                    if (hi_run != HALF_DIV) hi_bad <= 1'b1;
                    hi_run <= 0;
                end
                if (byte_ready_o && byte_valid_i && !byte_err_i) byte_idx <= byte_idx + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int flag_code();
        if (ok_o) return 0;
        if (err_init_o) return 1;
        if (err_done_o) return 2;
        if (err_src_o) return 3;
        return 9;
    endfunction

    task automatic run_load(input int v, input logic [47:0] f, input int restart_at);
        int code, exp_p, exp_b, bad_bytes, cyc;
        vlen   = int'(f[47:40]);
        videl  = int'(f[39:32]);
        vdext  = int'(f[31:24]);
        verr   = int'(f[23:16]);
        vstall = int'(f[15:8]);
        code   = int'(f[7:0]);
        vidx   = v;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        // R2 and R9: a new load clears the old result flag
        chk(busy_o && !prog_n_o && flag_code() == 9, "R2/R9 busy and program after start",
            {busy_o, prog_n_o}, 2);
        cyc = 0;
        while (busy_o && cyc < 4000) begin
            if (restart_at != 0 && cyc == restart_at) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        chk(cyc < 4000, "R10 load terminates", cyc, 4000);
        chk(flag_code() == code, "R10 result flag", flag_code(), code);
        case (code)
            0: exp_p = 8 * vlen + vdext;
            1: exp_p = 0;
            2: exp_p = 8 * vlen + DONE_TO;
            default: exp_p = 8 * verr;
        endcase
        exp_b = (code == 1) ? 0 : ((code == 3) ? verr : vlen);
        chk(pulses == exp_p, "R5/R6/R7/R8 pulse count", pulses, exp_p);
        chk(nbytes == exp_b, "R5 byte count", nbytes, exp_b);
        bad_bytes = 0;
        for (int i = 0; i < exp_b && i < 64; i++)
            if (cap_mem[i] != img_byte(v, i)) bad_bytes++;
        chk(bad_bytes == 0, "R4 MSB-first data", bad_bytes, 0);
        chk(prog_width == PROG_LOW, "R2 program pulse width", prog_width, PROG_LOW);
        chk(!hi_bad, "R4 clock high width", int'(hi_bad), 0);
        if (code == 1)
            chk(wait_cyc == INIT_TO + 1, "R3 init wait cycles", wait_cyc, INIT_TO + 1);
        repeat (4) @(negedge clk);
        chk(flag_code() == code && !busy_o, "R10 flag holds", flag_code(), code);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R10: got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(prog_n_o && !cfg_clk_o && !busy_o && !byte_ready_o, "R1 pins in reset",
            {prog_n_o, cfg_clk_o, busy_o, byte_ready_o}, 8);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(prog_n_o && !cfg_clk_o && !busy_o && !byte_ready_o && flag_code() == 9,
            "R1 idle after reset", flag_code(), 9);

        for (int k = 0; k < 7; k++) run_load(k, VECS[k], 0);

        // R9: start pulse in the middle of a load is ignored
        run_load(7, VECS[0], 30);
        // R3: init timeout again, followed by a restart that succeeds
        run_load(8, VECS[2], 0);
        run_load(9, VECS[1], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule